// File: doc/BRIEF.md
# Card Host Data Buffer with Threshold DMA Requests

This block is the data staging buffer of a memory-card host controller. It holds up to 32 words of 16 bits in a circular store. The CPU writes and reads the store through a small register port. A card-side transfer engine pushes and pops words through dedicated strobes. One register port address selects the data word and the other selects a buffer configuration word.

The configuration word sets two fill thresholds and, for each direction, whether crossing the threshold drives a DMA request line or a CPU-visible flag. Card-to-host traffic compares the fill count against the upper threshold. Host-to-card traffic compares it against the lower threshold. When no transfer is running and the store is empty, both flags drop and the request lines keep their value. The command logic asserts a clear strobe when a data command starts, which empties the store.

All four status outputs are registered. They reflect the fill count and configuration that exist after the clock edge on which a push, pop, clear or configuration write takes effect.

Top module: `cardbuf_dma_fifo`

## Requirements
- R1: After reset the fill count is 0, the upper threshold is 31, the lower threshold is 0, both DMA enables are 0, and all four request and flag outputs are 0. A configuration read then returns 0x1F00.
- R2: Words leave the store in the order they entered. The read and write positions wrap modulo 32. A data read returns its word on `cpu_rdata` in the cycle after the read strobe; an engine pop returns its word on `eng_pop_data` in the cycle after the pop strobe.
- R3: A push while the store holds 32 words is dropped: the count and the stored words stay unchanged.
- R4: A pop or data read while the store is empty returns the word at the read position and leaves the read position and count unchanged.
- R5: With `dir_rx`=1, the count above the upper threshold and receive DMA enabled, `rx_dma_req` is 1 and `rx_flag` is 0.
- R6: With `dir_rx`=1, the count above the upper threshold and receive DMA disabled, `rx_flag` is 1 and `rx_dma_req` keeps its value. Otherwise, outside the idle case of R9, both `rx_dma_req` and `rx_flag` are 0.
- R7: With `dir_rx`=0, the count below the lower threshold and transmit DMA enabled, `tx_dma_req` is 1 and `tx_flag` is 0.
- R8: With `dir_rx`=0, the count below the lower threshold and transmit DMA disabled, `tx_flag` is 1 and `tx_dma_req` keeps its value. Otherwise, outside the idle case of R9, both `tx_dma_req` and `tx_flag` are 0.
- R9: When `xfer_active` is 0 and the resulting count is 0, both flags become 0 and both request lines keep their value.
- R10: A configuration write that sets a DMA enable clears the matching flag in the same update that applies the write.
- R11: `fifo_clear` sets the count and both positions to 0. It takes precedence over any push or pop in the same cycle.
- R12: The configuration word has this layout:
  - bit 15: receive DMA enable;
  - bits 12:8: upper threshold;
  - bit 7: transmit DMA enable;
  - bits 4:0: lower threshold;
  - all other bits: read as 0.
- R13: Request and flag outputs are registered. They reflect the state produced at the clock edge on which the push, pop, clear or configuration write is sampled. A CPU data access takes the buffer port ahead of an engine strobe of the same kind in the same cycle; the engine strobe is then dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_wr_en | input | 1 | CPU register write strobe |
| cpu_rd_en | input | 1 | CPU register read strobe |
| cpu_sel | input | 1 | Register select: 0 data word, 1 configuration word |
| cpu_wdata | input | 16 | CPU write data |
| cpu_rdata | output | 16 | CPU read data, valid the cycle after the read strobe |
| xfer_active | input | 1 | A data transfer is in progress |
| dir_rx | input | 1 | 1 card-to-host, 0 host-to-card |
| fifo_clear | input | 1 | Empty the store (data command start) |
| eng_push | input | 1 | Transfer engine push strobe |
| eng_push_data | input | 16 | Word pushed by the engine |
| eng_pop | input | 1 | Transfer engine pop strobe |
| eng_pop_data | output | 16 | Word popped, valid the cycle after the pop strobe |
| rx_dma_req | output | 1 | Receive DMA request |
| tx_dma_req | output | 1 | Transmit DMA request |
| rx_flag | output | 1 | Receive threshold status flag (unmasked) |
| tx_flag | output | 1 | Transmit threshold status flag (unmasked) |

## Verification
Directed sequences fill the store across each threshold in both directions, once with DMA enabled and once with it disabled. This separates a request line from its flag and shows whether a stale request is held. Further directed runs fill the store to 32 and push once more, read past empty, clear in mid-fill, and drop the transfer-active input with a request high; these reach the drop, no-move, clear-precedence and hold rules. A long seeded random mix then interleaves CPU and engine traffic, configuration rewrites, clears and direction changes. This exposes the pointer wrap, same-cycle push and pop, and CPU-over-engine arbitration, checked against a reference model in the bench.

// File: rtl/cardbuf_pkg.sv
package cardbuf_pkg;

  localparam int LVL_W = 5;

  typedef enum logic {
    SEL_DATA = 1'b0,
    SEL_CFG  = 1'b1
  } reg_sel_e;

  typedef struct packed {
    logic             rx_en;
    logic [LVL_W-1:0] hi_lvl;
    logic             tx_en;
    logic [LVL_W-1:0] lo_lvl;
  } buf_cfg_t;

  localparam buf_cfg_t CFG_RESET = '{rx_en: 1'b0, hi_lvl: 5'd31, tx_en: 1'b0, lo_lvl: 5'd0};

  function automatic buf_cfg_t cfg_unpack(input logic [15:0] w);
    buf_cfg_t c;
    c.rx_en  = w[15];
    c.hi_lvl = w[12:8];
    c.tx_en  = w[7];
    c.lo_lvl = w[4:0];
    return c;
  endfunction

  function automatic logic [15:0] cfg_pack(input buf_cfg_t c);
    return {c.rx_en, 2'b00, c.hi_lvl, c.tx_en, 2'b00, c.lo_lvl};
  endfunction

endpackage

// File: rtl/cardbuf_ram.sv
module cardbuf_ram #(
  parameter int DW = 16,
  parameter int DEPTH = 32,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/cardbuf_ptrs.sv
module cardbuf_ptrs #(
  parameter int DEPTH = 32,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          push,
  input  logic          pop,
  output logic          push_ok,
  output logic          pop_ok,
  output logic [AW-1:0] wr_ptr,
  output logic [AW-1:0] rd_ptr,
  output logic [CW-1:0] cnt_q,
  output logic [CW-1:0] cnt_n
);

  localparam logic [CW-1:0] FULL = CW'(DEPTH);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  assign push_ok = push && (cnt_q != FULL) && !clear;
  assign pop_ok  = pop && (cnt_q != '0) && !clear;

  always_comb begin
    if (clear) cnt_n = '0;
    else       cnt_n = cnt_q + CW'(push_ok) - CW'(pop_ok);
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_q  <= '0;
    end else begin
      cnt_q <= cnt_n;
      if (push_ok) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (pop_ok)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
    end
  end

endmodule

// File: rtl/cardbuf_levels.sv
module cardbuf_levels
  import cardbuf_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          xfer_active,
  input  logic          dir_rx,
  input  logic [CW-1:0] cnt_n,
  input  buf_cfg_t      cfg_n,
  output logic          rx_req,
  output logic          tx_req,
  output logic          rx_flag,
  output logic          tx_flag
);

  logic rx_hit, tx_hit, idle_empty;

  assign rx_hit     = dir_rx && (cnt_n > CW'(cfg_n.hi_lvl));
  assign tx_hit     = !dir_rx && (cnt_n < CW'(cfg_n.lo_lvl));
  assign idle_empty = !xfer_active && (cnt_n == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_req  <= 1'b0;
      tx_req  <= 1'b0;
      rx_flag <= 1'b0;
      tx_flag <= 1'b0;
    end else if (idle_empty) begin
      rx_flag <= 1'b0;
      tx_flag <= 1'b0;
    end else begin
      if (rx_hit) begin
        if (cfg_n.rx_en) begin
          rx_req  <= 1'b1;
          rx_flag <= 1'b0;
        end else begin
          rx_flag <= 1'b1;
        end
      end else begin
        rx_req  <= 1'b0;
        rx_flag <= 1'b0;
      end
      if (tx_hit) begin
        if (cfg_n.tx_en) begin
          tx_req  <= 1'b1;
          tx_flag <= 1'b0;
        end else begin
          tx_flag <= 1'b1;
        end
      end else begin
        tx_req  <= 1'b0;
        tx_flag <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/cardbuf_dma_fifo.sv
module cardbuf_dma_fifo
  import cardbuf_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cpu_wr_en,
  input  logic          cpu_rd_en,
  input  logic          cpu_sel,
  input  logic [DW-1:0] cpu_wdata,
  output logic [DW-1:0] cpu_rdata,
  input  logic          xfer_active,
  input  logic          dir_rx,
  input  logic          fifo_clear,
  input  logic          eng_push,
  input  logic [DW-1:0] eng_push_data,
  input  logic          eng_pop,
  output logic [DW-1:0] eng_pop_data,
  output logic          rx_dma_req,
  output logic          tx_dma_req,
  output logic          rx_flag,
  output logic          tx_flag
);

  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic          cpu_dat_wr, cpu_dat_rd, cpu_cfg_wr;
  logic          push, pop, push_ok, pop_ok;
  logic [DW-1:0] push_data, ram_q;
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt_q, cnt_n;
  buf_cfg_t      cfg_q, cfg_n;
  logic          sel_q;
  logic [15:0]   cfg_rd_q;

  assign cpu_dat_wr = cpu_wr_en && (cpu_sel == SEL_DATA);
  assign cpu_dat_rd = cpu_rd_en && (cpu_sel == SEL_DATA);
  assign cpu_cfg_wr = cpu_wr_en && (cpu_sel == SEL_CFG);

  assign push      = cpu_dat_wr || eng_push;
  assign push_data = cpu_dat_wr ? cpu_wdata : eng_push_data;
  assign pop       = cpu_dat_rd || eng_pop;

  assign cfg_n = cpu_cfg_wr ? cfg_unpack(cpu_wdata[15:0]) : cfg_q;

  cardbuf_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk(clk), .rst(rst), .clear(fifo_clear), .push(push), .pop(pop),
    .push_ok(push_ok), .pop_ok(pop_ok), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr),
    .cnt_q(cnt_q), .cnt_n(cnt_n)
  );

  cardbuf_ram #(.DW(DW), .DEPTH(DEPTH)) u_ram (
    .clk(clk), .we(push_ok), .waddr(wr_ptr), .wdata(push_data),
    .re(pop), .raddr(rd_ptr), .rdata(ram_q)
  );

  cardbuf_levels #(.DEPTH(DEPTH)) u_levels (
    .clk(clk), .rst(rst), .xfer_active(xfer_active), .dir_rx(dir_rx),
    .cnt_n(cnt_n), .cfg_n(cfg_n), .rx_req(rx_dma_req), .tx_req(tx_dma_req),
    .rx_flag(rx_flag), .tx_flag(tx_flag)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q    <= CFG_RESET;
      sel_q    <= SEL_DATA;
      cfg_rd_q <= '0;
    end else begin
      cfg_q <= cfg_n;
      if (cpu_rd_en) begin
        sel_q <= cpu_sel;
        if (cpu_sel == SEL_CFG) cfg_rd_q <= cfg_pack(cfg_q);
      end
    end
  end

  assign cpu_rdata    = (sel_q == SEL_CFG) ? DW'(cfg_rd_q) : ram_q;
  assign eng_pop_data = ram_q;

endmodule

// File: rtl/cardbuf_dma_fifo_chk.sv
module cardbuf_dma_fifo_chk #(
  parameter int DEPTH = 32,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input logic          clk,
  input logic          rst,
  input logic          dir_rx,
  input logic          fifo_clear,
  input logic          rx_dma_req,
  input logic          tx_dma_req,
  input logic          rx_flag,
  input logic          tx_flag,
  input logic          rx_en,
  input logic          tx_en,
  input logic          push,
  input logic          pop,
  input logic [AW-1:0] rd_ptr,
  input logic [CW-1:0] fill
);

  // R3
  fill_bound_chk: assert property (@(posedge clk) disable iff (rst)
    fill <= CW'(DEPTH));

  // R4
  empty_pop_chk: assert property (@(posedge clk) disable iff (rst)
    (fill == '0 && pop && !push && !fifo_clear) |=> (fill == '0 && $stable(rd_ptr)));

  // R5
  rx_req_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_dma_req) |-> (rx_en && $past(dir_rx)));

  // R7
  tx_req_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_dma_req) |-> (tx_en && !$past(dir_rx)));

  // R6
  rx_flag_dma_off_chk: assert property (@(posedge clk) disable iff (rst)
    rx_flag |-> !rx_en);

  // R8
  tx_flag_dma_off_chk: assert property (@(posedge clk) disable iff (rst)
    tx_flag |-> !tx_en);

  // R11
  clear_empties_chk: assert property (@(posedge clk) disable iff (rst)
    fifo_clear |=> (fill == '0 && rd_ptr == '0));

endmodule

bind cardbuf_dma_fifo cardbuf_dma_fifo_chk #(.DEPTH(DEPTH)) i_chk (
  .clk(clk), .rst(rst), .dir_rx(dir_rx), .fifo_clear(fifo_clear),
  .rx_dma_req(rx_dma_req), .tx_dma_req(tx_dma_req),
  .rx_flag(rx_flag), .tx_flag(tx_flag),
  .rx_en(cfg_q.rx_en), .tx_en(cfg_q.tx_en),
  .push(push), .pop(pop), .rd_ptr(rd_ptr), .fill(cnt_q)
);

// File: tb/test_cardbuf_dma_fifo.sv
module test_cardbuf_dma_fifo;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cpu_wr_en = 0, cpu_rd_en = 0, cpu_sel = 0;
  logic [15:0] cpu_wdata = '0, cpu_rdata;
  logic        xfer_active = 0, dir_rx = 0, fifo_clear = 0;
  logic        eng_push = 0, eng_pop = 0;
  logic [15:0] eng_push_data = '0, eng_pop_data;
  logic        rx_dma_req, tx_dma_req, rx_flag, tx_flag;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  cardbuf_dma_fifo i_cardbuf_dma_fifo (
    .clk(clk), .rst(rst), .cpu_wr_en(cpu_wr_en), .cpu_rd_en(cpu_rd_en),
    .cpu_sel(cpu_sel), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .xfer_active(xfer_active), .dir_rx(dir_rx), .fifo_clear(fifo_clear),
    .eng_push(eng_push), .eng_push_data(eng_push_data), .eng_pop(eng_pop),
    .eng_pop_data(eng_pop_data), .rx_dma_req(rx_dma_req), .tx_dma_req(tx_dma_req),
    .rx_flag(rx_flag), .tx_flag(tx_flag)
  );

  // reference model
  logic [15:0] m_mem [32];
  int          m_rp, m_wp, m_cnt;
  logic        m_rxen, m_txen;
  logic [4:0]  m_hi, m_lo;
  logic        m_rxq, m_txq, m_rxf, m_txf;
  logic        m_sel;
  logic [15:0] m_rq, m_cfgrd;

  function automatic logic [15:0] m_pack();
    return {m_rxen, 2'b00, m_hi, m_txen, 2'b00, m_lo};
  endfunction

  task automatic m_reset();
    m_rp = 0; m_wp = 0; m_cnt = 0;
    m_rxen = 0; m_txen = 0; m_hi = 5'd31; m_lo = 5'd0;
    m_rxq = 0; m_txq = 0; m_rxf = 0; m_txf = 0;
    m_sel = 0; m_cfgrd = '0;
  endtask

  task automatic m_step();
    logic cdw, cdr, psh, pp, pok, qok;
    logic [15:0] pd;
    cdw = cpu_wr_en && !cpu_sel;
    cdr = cpu_rd_en && !cpu_sel;
    psh = cdw || eng_push;
    pd  = cdw ? cpu_wdata : eng_push_data;
    pp  = cdr || eng_pop;
    if (pp) m_rq = m_mem[m_rp];
    if (cpu_rd_en) begin
      m_sel = cpu_sel;
      if (cpu_sel) m_cfgrd = m_pack();
    end
    pok = psh && m_cnt != 32;
    qok = pp && m_cnt != 0;
    if (fifo_clear) begin
      m_rp = 0; m_wp = 0; m_cnt = 0;
    end else begin
      if (pok) begin m_mem[m_wp] = pd; m_wp = (m_wp + 1) % 32; end
      if (qok) m_rp = (m_rp + 1) % 32;
      m_cnt = m_cnt + int'(pok) - int'(qok);
    end
    if (cpu_wr_en && cpu_sel) begin
      m_rxen = cpu_wdata[15]; m_hi = cpu_wdata[12:8];
      m_txen = cpu_wdata[7];  m_lo = cpu_wdata[4:0];
    end
    if (!xfer_active && m_cnt == 0) begin
      m_rxf = 0; m_txf = 0;
    end else begin
      if (dir_rx && m_cnt > int'(m_hi)) begin
        if (m_rxen) begin m_rxq = 1; m_rxf = 0; end else m_rxf = 1;
      end else begin m_rxq = 0; m_rxf = 0; end
      if (!dir_rx && m_cnt < int'(m_lo)) begin
        if (m_txen) begin m_txq = 1; m_txf = 0; end else m_txf = 1;
      end else begin m_txq = 0; m_txf = 0; end
    end
  endtask

  task automatic chk(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic check_outs(input string tag);
    chk(tag, "rx_dma_req", 16'(rx_dma_req), 16'(m_rxq));
    chk(tag, "tx_dma_req", 16'(tx_dma_req), 16'(m_txq));
    chk(tag, "rx_flag", 16'(rx_flag), 16'(m_rxf));
    chk(tag, "tx_flag", 16'(tx_flag), 16'(m_txf));
  endtask

  // one cycle: called at a negedge with stimulus already applied
  task automatic cyc(input string tag);
    logic did_rd, did_pop;
    did_rd  = cpu_rd_en;
    did_pop = eng_pop;
    m_step();
    @(posedge clk);
    @(negedge clk);
    cpu_wr_en = 0; cpu_rd_en = 0; cpu_sel = 0;
    eng_push = 0; eng_pop = 0; fifo_clear = 0;
    check_outs(tag);
    if (did_rd) chk(tag, "cpu_rdata", cpu_rdata, m_sel ? m_cfgrd : m_rq);
    if (did_pop) chk(tag, "eng_pop_data", eng_pop_data, m_rq);
  endtask

  task automatic wr_cfg(input string tag, input logic [15:0] v);
    cpu_wr_en = 1; cpu_sel = 1; cpu_wdata = v; cyc(tag);
  endtask
  task automatic rd_cfg(input string tag);
    cpu_rd_en = 1; cpu_sel = 1; cyc(tag);
  endtask
  task automatic cpu_put(input string tag, input logic [15:0] v);
    cpu_wr_en = 1; cpu_sel = 0; cpu_wdata = v; cyc(tag);
  endtask
  task automatic cpu_get(input string tag);
    cpu_rd_en = 1; cpu_sel = 0; cyc(tag);
  endtask
  task automatic eng_put(input string tag, input logic [15:0] v);
    eng_push = 1; eng_push_data = v; cyc(tag);
  endtask
  task automatic do_clear(input string tag);
    fifo_clear = 1; cyc(tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    m_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    // R1 reset state
    check_outs("R1");
    rd_cfg("R1");
    chk("R1", "cfg_reset", cpu_rdata, 16'h1F00);

    // R12 field layout read-back
    wr_cfg("R12", 16'hFFFF);
    rd_cfg("R12");
    chk("R12", "cfg_mask", cpu_rdata, 16'h9F9F);

    // R5 / R13: receive DMA above upper threshold 3
    xfer_active = 1; dir_rx = 1;
    wr_cfg("R5", 16'h8300);
    for (int i = 0; i < 3; i++) eng_put("R13", 16'hA000 + 16'(i));
    chk("R13", "rx_req_at3", 16'(rx_dma_req), 16'd0);
    eng_put("R5", 16'hA003);
    chk("R5", "rx_req_at4", 16'(rx_dma_req), 16'd1);
    for (int i = 0; i < 4; i++) cpu_get("R2");

    // R6: DMA off, flag set, request holds
    wr_cfg("R6", 16'h8000);
    eng_put("R6", 16'hB000);
    chk("R6", "rx_req_on", 16'(rx_dma_req), 16'd1);
    wr_cfg("R6", 16'h0000);
    eng_put("R6", 16'hB001);
    chk("R6", "rx_flag_set", 16'(rx_flag), 16'd1);
    chk("R6", "rx_req_hold", 16'(rx_dma_req), 16'd1);
    // R10: enabling receive DMA clears the flag at once
    wr_cfg("R10", 16'h8000);
    chk("R10", "rx_flag_clr", 16'(rx_flag), 16'd0);
    cpu_get("R2"); cpu_get("R2");

    // R7 / R8: transmit side against lower threshold 4
    dir_rx = 0;
    wr_cfg("R7", 16'h0084);
    chk("R7", "tx_req", 16'(tx_dma_req), 16'd1);
    for (int i = 0; i < 4; i++) cpu_put("R7", 16'hC000 + 16'(i));
    chk("R7", "tx_req_off", 16'(tx_dma_req), 16'd0);
    do_clear("R11");
    chk("R11", "tx_req_after_clear", 16'(tx_dma_req), 16'd1);
    wr_cfg("R8", 16'h0004);
    chk("R8", "tx_flag", 16'(tx_flag), 16'd1);
    wr_cfg("R10", 16'h0084);
    chk("R10", "tx_flag_clr", 16'(tx_flag), 16'd0);

    // R3: fill to 32, extra write dropped; R2 order and wrap
    wr_cfg("R3", 16'h1F00);
    for (int i = 0; i < 32; i++) cpu_put("R2", 16'h5000 + 16'(i));
    cpu_put("R3", 16'hDEAD);
    for (int i = 0; i < 32; i++) begin
      cpu_get("R2");
      chk("R2", "order", cpu_rdata, 16'h5000 + 16'(i));
    end
    // R4: read while empty returns slot at read position, no movement
    cpu_get("R4");
    chk("R4", "empty_read", cpu_rdata, 16'h5000);
    cpu_get("R4");
    chk("R4", "empty_read2", cpu_rdata, 16'h5000);
    cpu_put("R4", 16'h7777);
    cpu_get("R4");
    chk("R4", "after_empty", cpu_rdata, 16'h7777);

    // R9: idle and empty drops flags, keeps request
    dir_rx = 1;
    wr_cfg("R9", 16'h8000);
    eng_put("R9", 16'h1111);
    chk("R9", "rx_req_up", 16'(rx_dma_req), 16'd1);
    xfer_active = 0;
    do_clear("R9");
    chk("R9", "rx_req_held", 16'(rx_dma_req), 16'd1);
    chk("R9", "rx_flag_low", 16'(rx_flag), 16'd0);

    // R11: clear beats a same-cycle push
    xfer_active = 1;
    eng_put("R11", 16'h2222);
    eng_put("R11", 16'h3333);
    fifo_clear = 1; eng_push = 1; eng_push_data = 16'h4444; cyc("R11");
    eng_put("R11", 16'h5555);
    cpu_get("R11");
    chk("R11", "first_after_clear", cpu_rdata, 16'h5555);

    // random phase
    void'($urandom(32'd20240611));
    for (int n = 0; n < 4000; n++) begin
      int r;
      r = int'($urandom % 32);
      if (r == 0) xfer_active = ~xfer_active;
      if (r == 1) dir_rx = ~dir_rx;
      cpu_wr_en = ($urandom % 3) == 0;
      cpu_rd_en = ($urandom % 3) == 0;
      cpu_sel   = ($urandom % 12) == 0;
      cpu_wdata = 16'($urandom);
      eng_push  = ($urandom % 3) == 0;
      eng_push_data = 16'($urandom);
      eng_pop   = ($urandom % 3) == 0;
      fifo_clear = ($urandom % 60) == 0;
      cyc("R13");
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule